// File: doc/BRIEF.md
# I2C Slave Sleep Wakeup Front-End

This block keeps watch over an I2C bus while the main slave logic sleeps with its clock gated off. It runs from a small always-on sampling clock and passes both bus lines through synchronisers. When it sees a START, it pulls SCL low and raises a clock request toward the power manager. It holds the bus until the power manager reports through a ready input that the slave clock is running, so the master cannot clock bits in before the device can take them.

Once SCL is released, the block shifts in one byte. A byte whose upper five bits are `00001` is a high-speed master code. The block is never meant to acknowledge it. It sets a high-speed flag, waits for the repeated START, and then shifts in the address byte. If the upper seven bits of the address byte equal the configured slave address, the block drops the clock request and raises a wake level for the whole device, which then takes over normal handling. If they do not match, the block drops the clock request so the device falls back to sleep. The high-speed flag stays set until a STOP is seen on the bus.

All pins are plain levels. There is no data stream, so no valid/ready interface is involved. `scl_pull` is the enable for an open-drain pull-down on SCL. The block never drives SDA.

Top module: `i2c_wake_frontend`

## Requirements
- R1: Outputs `scl_pull` and `clk_req` both go high within four sampling-clock cycles after a START (SDA falling while SCL is high) that arrives while the block is idle.
- R2: While `clk_rdy` is low after such a START, `scl_pull` stays high and the bus SCL stays low, however long the wait, even when the master releases SCL.
- R3: `scl_pull` falls within two cycles of `clk_rdy` being seen high, and no fixed count ever releases it.
- R4: When the first byte is not a master code and its bits [7:1] equal `own_addr`, `wake_req` rises and `clk_req` falls after the eighth SCL rising edge. Bit 0, the direction bit, is ignored. `wake_req` stays high until a STOP.
- R5: When the first byte is neither a master code nor a match, `clk_req` falls and `wake_req` stays low after the eighth SCL rising edge.
- R6: A first byte with bits [7:3] equal to `00001` sets `hs_mode` and keeps `clk_req` high with SCL free. The byte after the next repeated START is then matched as in R4 and R5.
- R7: Once set, `hs_mode` stays high through non-matching addresses and later STARTs, and it clears only on a STOP.
- R8: A STOP at any point returns the block to idle, with `clk_req`, `wake_req` and `scl_pull` low.
- R9: After reset, `scl_pull`, `clk_req`, `wake_req` and `hs_mode` are all low.
- R10: SCL clocking without a preceding START has no effect. Even a full matching address byte leaves all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL level seen at the pad |
| sda_in | input | 1 | SDA level seen at the pad |
| own_addr | input | ADDR_W | Configured 7-bit slave address |
| clk_rdy | input | 1 | Power manager reports the slave clock running |
| scl_pull | output | 1 | Enable for the open-drain pull-down on SCL |
| clk_req | output | 1 | Request to start the slave clock |
| wake_req | output | 1 | Full-device wake request |
| hs_mode | output | 1 | Bus is in high-speed mode |

## Verification
The hardest state to reach is the high-speed path that ends in a miss: a master code, the unacknowledged ninth clock, a repeated START, a non-matching address, and then a new START that has to stretch SCL again while `hs_mode` is still set. The bench reaches it with a bit-level master model. That model honours clock stretching by waiting for the wired-AND SCL to read high. Every one of the 256 first-byte values is swept, with the ready delay varied per byte, and master codes are paired with matching and non-matching addresses according to one of the byte's low bits.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STRETCH,
    ST_FIRST,
    ST_WAIT_RS,
    ST_ADDR,
    ST_AWAKE
  } wake_state_e;

  localparam int MC_TAG_W = 5;
  localparam logic [MC_TAG_W-1:0] MC_TAG = 5'b00001;
endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] cur,
  output logic [LINES-1:0] prev
);
  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      logic              last;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '1;
          last  <= 1'b1;
        end else begin
          chain <= {chain[STAGES-2:0], raw[g]};
          last  <= chain[STAGES-1];
        end
      end
      assign cur[g]  = chain[STAGES-1];
      assign prev[g] = last;
    end
  endgenerate
endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events (
  input  logic scl_cur,
  input  logic scl_prev,
  input  logic sda_cur,
  input  logic sda_prev,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise
);
  always_comb begin
    start_det = scl_cur && scl_prev && sda_prev && !sda_cur;
    stop_det  = scl_cur && scl_prev && !sda_prev && sda_cur;
    scl_rise  = scl_cur && !scl_prev;
  end
endmodule

// File: rtl/i2cw_byte_rx.sv
module i2cw_byte_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              din,
  output logic [BYTE_W-1:0] next_byte,
  output logic              done
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  assign next_byte = {shreg[BYTE_W-2:0], din};
  assign done      = shift_en && (cnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (clear) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (shift_en) begin
      shreg <= next_byte;
      cnt   <= cnt + 1'b1;
    end
  end

  // R4: a byte never takes more than BYTE_W shifts
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(BYTE_W));
endmodule

// File: rtl/i2c_wake_frontend.sv
module i2c_wake_frontend #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              clk_rdy,
  output logic              scl_pull,
  output logic              clk_req,
  output logic              wake_req,
  output logic              hs_mode
);
  import i2cw_pkg::*;

  localparam int BYTE_W = ADDR_W + 1;

  logic [1:0]        line_cur, line_prev;
  logic              start_det, stop_det, scl_rise;
  logic              shift_en, byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              is_mc, is_match;
  wake_state_e       state;

  i2cw_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .raw ({sda_in, scl_in}),
    .cur (line_cur),
    .prev (line_prev)
  );

  i2cw_bus_events u_events (
    .scl_cur (line_cur[0]),
    .scl_prev (line_prev[0]),
    .sda_cur (line_cur[1]),
    .sda_prev (line_prev[1]),
    .start_det (start_det),
    .stop_det (stop_det),
    .scl_rise (scl_rise)
  );

  assign shift_en = scl_rise && (state == ST_FIRST || state == ST_ADDR);

  i2cw_byte_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk (clk),
    .rst_n (rst_n),
    .clear (start_det),
    .shift_en (shift_en),
    .din (line_cur[1]),
    .next_byte (rx_byte),
    .done (byte_done)
  );

  assign is_mc    = (rx_byte[BYTE_W-1 -: MC_TAG_W] == MC_TAG);
  assign is_match = (rx_byte[BYTE_W-1:1] == own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      hs_mode <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      hs_mode <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:    if (start_det) state <= ST_STRETCH;
        ST_STRETCH: if (clk_rdy) state <= ST_FIRST;
        ST_FIRST: begin
          if (byte_done) begin
            if (is_mc) begin
              hs_mode <= 1'b1;
              state   <= ST_WAIT_RS;
            end else if (is_match) begin
              state <= ST_AWAKE;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_WAIT_RS: if (start_det) state <= ST_ADDR;
        ST_ADDR: begin
          if (byte_done) state <= is_match ? ST_AWAKE : ST_IDLE;
        end
        ST_AWAKE:   state <= ST_AWAKE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_pull = (state == ST_STRETCH);
    clk_req  = (state == ST_STRETCH) || (state == ST_FIRST) ||
               (state == ST_WAIT_RS) || (state == ST_ADDR);
    wake_req = (state == ST_AWAKE);
  end

  // R1: an idle START stretches SCL and requests the clock
  p_stretch_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_det && !stop_det) |=> (scl_pull && clk_req));

  // R2: the stretch holds while the clock is not ready
  p_hold_until_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && !clk_rdy && !stop_det) |=> scl_pull);

  // R3: ready releases SCL on the next edge
  p_release_on_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && clk_rdy && !stop_det) |=> !scl_pull);

  // R4: wake follows a completed byte while the clock was requested
  p_wake_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> ($past(clk_req) && $past(byte_done)));

  // R4: stretching and waking never overlap
  p_pull_wake_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_pull, wake_req}));

  // R6: high-speed mode only starts from the first byte
  p_hs_from_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> $past(state == ST_FIRST));

  // R7/R8: STOP clears everything
  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!hs_mode && !wake_req && !clk_req && !scl_pull));
endmodule

// File: tb/i2c_wake_frontend_test.sv
module i2c_wake_frontend_test;
  localparam int CLK_P = 10;
  localparam int HB    = 4;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, clk_rdy = 1'b0;
  logic scl_pull, clk_req, wake_req, hs_mode;
  wire  scl_bus = scl_m & ~scl_pull;
  wire  sda_bus = sda_m;
  int   n_chk = 0, n_err = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_wake_frontend uut (
    .clk (clk), .rst_n (rst_n), .scl_in (scl_bus), .sda_in (sda_bus),
    .own_addr (OWN), .clk_rdy (clk_rdy), .scl_pull (scl_pull),
    .clk_req (clk_req), .wake_req (wake_req), .hs_mode (hs_mode)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_scl_high();
    while (scl_bus !== 1'b1) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wclk(HB);
    scl_m = 1'b1; wait_scl_high(); wclk(HB);
    scl_m = 1'b0; wclk(HB);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  // START, stretch checks, first bit clocked in after ready
  task automatic do_start(input int d, input logic first, input logic hs_exp);
    sda_m = 1'b1; wclk(HB);
    scl_m = 1'b1; wclk(HB);
    sda_m = 1'b0; wclk(HB);
    chk("R1 scl_pull after START", scl_pull, 1'b1);
    chk("R1 clk_req after START", clk_req, 1'b1);
    chk("R7 hs kept across START", hs_mode, hs_exp);
    scl_m = 1'b0; wclk(1);
    sda_m = first; wclk(1);
    scl_m = 1'b1; wclk(d);
    chk("R2 SCL held low before ready", scl_bus, 1'b0);
    chk("R2 scl_pull held", scl_pull, 1'b1);
    clk_rdy = 1'b1; wclk(2);
    chk("R3 released after ready", scl_pull, 1'b0);
    wait_scl_high(); wclk(HB);
    scl_m = 1'b0; wclk(HB);
  endtask

  task automatic rep_start();
    sda_m = 1'b1; wclk(HB);
    scl_m = 1'b1; wait_scl_high(); wclk(HB);
    sda_m = 1'b0; wclk(HB);
    scl_m = 1'b0; wclk(HB);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wclk(HB);
    scl_m = 1'b1; wait_scl_high(); wclk(HB);
    sda_m = 1'b1; wclk(HB);
  endtask

  initial begin
    wclk(3);
    chk("R9 reset scl_pull", scl_pull, 1'b0);
    chk("R9 reset clk_req", clk_req, 1'b0);
    chk("R9 reset wake_req", wake_req, 1'b0);
    chk("R9 reset hs_mode", hs_mode, 1'b0);
    rst_n = 1'b1; wclk(3);

    // R10: matching address clocked with no START
    scl_m = 1'b0; wclk(HB);
    send_bits({OWN, 1'b0}, 8);
    send_bit(1'b1);
    sda_m = 1'b1; wclk(HB); scl_m = 1'b1; wclk(HB);
    chk("R10 no clk_req without START", clk_req, 1'b0);
    chk("R10 no wake without START", wake_req, 1'b0);
    chk("R10 no stretch without START", scl_pull, 1'b0);

    // R8: STOP in the middle of the first byte
    do_start(3, 1'b0, 1'b0);
    send_bits(8'h05, 3);
    clk_rdy = 1'b0;
    do_stop();
    chk("R8 clk_req after STOP", clk_req, 1'b0);
    chk("R8 scl_pull after STOP", scl_pull, 1'b0);
    chk("R8 wake after STOP", wake_req, 1'b0);

    // Sweep of every first-byte value
    for (int b = 0; b < 256; b++) begin
      logic [7:0] v = 8'(b);
      logic mc = (v[7:3] == 5'b00001);
      logic hit = (v[7:1] == OWN);
      do_start(1 + (b % 7), v[7], 1'b0);
      send_bits(v, 7);
      if (mc) begin
        logic [7:0] a = v[0] ? {OWN, v[2]} : {OWN ^ 7'h40, v[2]};
        chk("R6 hs after master code", hs_mode, 1'b1);
        chk("R6 clk_req kept", clk_req, 1'b1);
        chk("R6 no wake on master code", wake_req, 1'b0);
        send_bit(1'b1);
        rep_start();
        chk("R6 clk_req after Sr", clk_req, 1'b1);
        chk("R6 no stretch after Sr", scl_pull, 1'b0);
        send_bits(a, 8);
        chk("R6 wake per address", wake_req, v[0]);
        chk("R6 clk_req dropped", clk_req, 1'b0);
        chk("R7 hs held after address", hs_mode, 1'b1);
      end else if (hit) begin
        chk("R4 wake on match", wake_req, 1'b1);
        chk("R4 clk_req dropped on match", clk_req, 1'b0);
      end else begin
        chk("R5 no wake on miss", wake_req, 1'b0);
        chk("R5 clk_req dropped on miss", clk_req, 1'b0);
        chk("R5 hs stays low", hs_mode, 1'b0);
      end
      send_bit(1'b1);
      if (hit && !mc) chk("R4 wake held past ack", wake_req, 1'b1);
      clk_rdy = 1'b0;
      do_stop();
      chk("R7 hs cleared on STOP", hs_mode, 1'b0);
      chk("R4 wake released on STOP", wake_req, 1'b0);
    end

    // R7: hs survives a miss and a fresh START, clears on STOP
    do_start(2, 1'b0, 1'b0);
    send_bits(8'h08, 7);
    send_bit(1'b1);
    rep_start();
    send_bits({OWN ^ 7'h40, 1'b1}, 8);
    chk("R7 miss drops clk_req", clk_req, 1'b0);
    chk("R7 hs after miss", hs_mode, 1'b1);
    send_bit(1'b1);
    clk_rdy = 1'b0;
    do_start(5, OWN[6], 1'b1);
    send_bits({OWN, 1'b0}, 7);
    chk("R7 wake in hs", wake_req, 1'b1);
    chk("R7 hs still set", hs_mode, 1'b1);
    send_bit(1'b1);
    clk_rdy = 1'b0;
    do_stop();
    chk("R7 hs cleared by STOP", hs_mode, 1'b0);
    chk("R7 wake cleared by STOP", wake_req, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule